// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits beside the command decoder of a synchronous DRAM model or controller. It turns one column command into the series of column addresses for the data beats of the burst. A small mode register is loaded from a 7-bit mode word. That word sets the burst length (1, 2, 4 or 8 beats, or a whole row), the beat order (wrapping sequential or XOR interleaved) and a read-latency code. The block only stores the latency code and drives it out for the data pipeline, which lies outside this block.

A column command starts a burst at the given start column. The first beat appears on the cycle after the command. One beat follows on each later cycle until the burst length is used up. A burst-stop request ends the burst early. A fresh column command on any cycle drops the burst in progress and starts a new one. Every beat is marked valid, and the final beat of a fixed-length burst is also marked last. A whole-row burst wraps around the row and never ends by itself.

Top module: `burst_colgen`

## Requirements
- R1: After reset `beat_valid` and `beat_last` are 0, and the mode register holds burst length 1, sequential order and latency code 2, so `rd_lat` reads 2.
- R2: In the mode word, bits [2:0] select the length, bit 3 selects the order (0 sequential, 1 interleaved), and bits [6:4] are the latency code. One cycle after `mode_wr` is high, `rd_lat` equals bits [6:4] of the word that was written.
- R3: When `col_cmd` is high, the next cycle shows `beat_valid`=1 and `beat_col` equal to the `col_start` value of the command cycle. The burst takes its settings from the mode register as it stood before that clock edge.
- R4: Length codes 000, 001, 010 and 011 give 1, 2, 4 and 8 beats. The reserved codes 100, 101 and 110 give 1 beat. `beat_last` is high on the final beat only, and `beat_valid` falls on the cycle after it unless a new command arrives.
- R5: In sequential order with length L, beat k carries the start column with its low log2(L) bits replaced by (start + k) mod L. The upper bits stay unchanged.
- R6: In interleaved order with a fixed length, beat k carries the start column XOR k.
- R7: Length code 111 is a whole-row burst. Beat k is (start + k) mod 2^COL_W, in sequential order whatever bit 3 holds. `beat_last` is never raised, and beats continue until a stop or a new command.
- R8: `burst_stop` without `col_cmd` makes `beat_valid` 0 on the next cycle, for every length. When both are high, the command wins.
- R9: A `col_cmd` during a burst restarts at beat 0 of the new start column on the next cycle.
- R10: A mode write during a burst leaves the remaining beats of that burst unchanged.
- R11: With no burst running and no `col_cmd`, `beat_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Load `mode_word` into the mode register |
| mode_word | input | 7 | Length [2:0], order [3], latency code [6:4] |
| col_cmd | input | 1 | Start a burst at `col_start` |
| col_start | input | COL_W | Start column of the burst |
| burst_stop | input | 1 | End the current burst |
| beat_valid | output | 1 | A beat address is present |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Final beat of a fixed-length burst |
| rd_lat | output | 3 | Stored latency code |

## Verification
The checker tests the cycle-level handshake on every cycle:
- a command produces a valid beat at the commanded column one cycle later;
- a stop clears valid;
- a last beat is followed by idle;
- a running burst keeps going until its last beat;
- the idle state holds;
- the latency code follows a mode write.

Only the bench scenarios can show the actual address order. That covers the wrap inside the block in sequential order, the XOR order, and the whole-row wrap from the top column back to 0. The bench also shows that each length code gives the right beat count and that a mode write does not disturb a running burst.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;

   typedef struct packed {
      logic [2:0] lat;
      logic       ilv;
      logic [2:0] len;
   } mode_t;

   localparam logic [2:0] LEN_ROW = 3'b111;

   // log2 of the beat count for fixed lengths; reserved codes act as one beat
   function automatic logic [3:0] len_log2(input logic [2:0] code);
      case (code)
         3'b001:  len_log2 = 4'd1;
         3'b010:  len_log2 = 4'd2;
         3'b011:  len_log2 = 4'd3;
         default: len_log2 = 4'd0;
      endcase
   endfunction

endpackage

// File: rtl/burst_colgen_mode.sv
module burst_colgen_mode
   import burst_colgen_pkg::*;
#(
   parameter logic [6:0] RST_MODE = 7'h20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_wr,
   input  logic [6:0] mode_word,
   output mode_t      mode_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)       mode_q <= mode_t'(RST_MODE);
      else if (mode_wr) mode_q <= mode_t'(mode_word);
   end

endmodule

// File: rtl/burst_colgen_seq.sv
module burst_colgen_seq
   import burst_colgen_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             col_cmd,
   input  logic [COL_W-1:0] col_start,
   input  logic             burst_stop,
   input  logic [2:0]       len_code,
   input  logic             ilv_in,
   output logic             valid_q,
   output logic [COL_W-1:0] cnt_q,
   output logic [COL_W-1:0] start_q,
   output logic [3:0]       lg_q,
   output logic             row_q,
   output logic             ilv_q,
   output logic             last
);

   localparam logic [COL_W-1:0] ONE = COL_W'(1);

   logic [COL_W-1:0] len_m1;

   assign len_m1 = (ONE << lg_q) - ONE;
   assign last   = valid_q && !row_q && (cnt_q == len_m1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         cnt_q   <= '0;
         start_q <= '0;
         lg_q    <= '0;
         row_q   <= 1'b0;
         ilv_q   <= 1'b0;
      end else if (col_cmd) begin
         valid_q <= 1'b1;
         cnt_q   <= '0;
         start_q <= col_start;
         lg_q    <= len_log2(len_code);
         row_q   <= (len_code == LEN_ROW);
         ilv_q   <= ilv_in;
      end else if (burst_stop) begin
         valid_q <= 1'b0;
      end else if (valid_q) begin
         if (last) valid_q <= 1'b0;
         else      cnt_q   <= cnt_q + ONE;
      end
   end

endmodule

// File: rtl/burst_colgen_map.sv
module burst_colgen_map #(
   parameter int COL_W = 10
) (
   input  logic [COL_W-1:0] start,
   input  logic [COL_W-1:0] cnt,
   input  logic [3:0]       lg,
   input  logic             row,
   input  logic             ilv,
   output logic [COL_W-1:0] col
);

   logic [COL_W-1:0] wrap_mask;
   logic [COL_W-1:0] sum;
   logic [COL_W-1:0] seq_col;

   genvar gi;
   generate
      for (gi = 0; gi < COL_W; gi++) begin : g_mask
         assign wrap_mask[gi] = row || (gi < int'(lg));
      end
   endgenerate

   assign sum     = start + cnt;
   assign seq_col = (start & ~wrap_mask) | (sum & wrap_mask);
   assign col     = (ilv && !row) ? (start ^ cnt) : seq_col;

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
   import burst_colgen_pkg::*;
#(
   parameter int         COL_W    = 10,
   parameter logic [6:0] RST_MODE = 7'h20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_wr,
   input  logic [6:0]       mode_word,
   input  logic             col_cmd,
   input  logic [COL_W-1:0] col_start,
   input  logic             burst_stop,
   output logic             beat_valid,
   output logic [COL_W-1:0] beat_col,
   output logic             beat_last,
   output logic [2:0]       rd_lat
);

   generate
      if (COL_W < 4 || COL_W > 16) begin : g_bad_width
         $error("burst_colgen: COL_W must lie in 4..16");
      end
   endgenerate

   mode_t            mode_q;
   logic [COL_W-1:0] cnt_q;
   logic [COL_W-1:0] start_q;
   logic [3:0]       lg_q;
   logic             row_q;
   logic             ilv_q;

   burst_colgen_mode #(.RST_MODE(RST_MODE)) mode_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_wr   (mode_wr),
      .mode_word (mode_word),
      .mode_q    (mode_q)
   );

   burst_colgen_seq #(.COL_W(COL_W)) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .col_cmd    (col_cmd),
      .col_start  (col_start),
      .burst_stop (burst_stop),
      .len_code   (mode_q.len),
      .ilv_in     (mode_q.ilv),
      .valid_q    (beat_valid),
      .cnt_q      (cnt_q),
      .start_q    (start_q),
      .lg_q       (lg_q),
      .row_q      (row_q),
      .ilv_q      (ilv_q),
      .last       (beat_last)
   );

   burst_colgen_map #(.COL_W(COL_W)) map_i (
      .start (start_q),
      .cnt   (cnt_q),
      .lg    (lg_q),
      .row   (row_q),
      .ilv   (ilv_q),
      .col   (beat_col)
   );

   assign rd_lat = mode_q.lat;

endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
   parameter int COL_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_wr,
   input logic [6:0]       mode_word,
   input logic             col_cmd,
   input logic [COL_W-1:0] col_start,
   input logic             burst_stop,
   input logic             beat_valid,
   input logic [COL_W-1:0] beat_col,
   input logic             beat_last,
   input logic [2:0]       rd_lat
);

   // R2
   lat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> rd_lat == $past(mode_word[6:4]));

   // R3
   cmd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_cmd |=> beat_valid && beat_col == $past(col_start));

   // R4
   last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last |-> beat_valid);

   // R4
   last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last && !col_cmd |=> !beat_valid);

   // R8
   stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      burst_stop && !col_cmd |=> !beat_valid);

   // R7
   run_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && !beat_last && !burst_stop && !col_cmd |=> beat_valid);

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !beat_valid && !col_cmd |=> !beat_valid);

endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_wr    (mode_wr),
   .mode_word  (mode_word),
   .col_cmd    (col_cmd),
   .col_start  (col_start),
   .burst_stop (burst_stop),
   .beat_valid (beat_valid),
   .beat_col   (beat_col),
   .beat_last  (beat_last),
   .rd_lat     (rd_lat)
);

// File: tb/burst_colgen_tb_top.sv
module burst_colgen_tb_top;

   localparam int COL_W = 10;
   localparam int CMASK = (1 << COL_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             mode_wr = 1'b0;
   logic [6:0]       mode_word = '0;
   logic             col_cmd = 1'b0;
   logic [COL_W-1:0] col_start = '0;
   logic             burst_stop = 1'b0;
   logic             beat_valid;
   logic [COL_W-1:0] beat_col;
   logic             beat_last;
   logic [2:0]       rd_lat;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // bench model state
   int m_len = 0, m_il = 0, m_lat = 2;
   int e_valid = 0, e_start = 0, e_cnt = 0, e_len = 1, e_il = 0, e_row = 0;

   always #10 clk = ~clk;

   burst_colgen #(.COL_W(COL_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_word(mode_word),
      .col_cmd(col_cmd), .col_start(col_start), .burst_stop(burst_stop),
      .beat_valid(beat_valid), .beat_col(beat_col), .beat_last(beat_last),
      .rd_lat(rd_lat)
   );

   function automatic int beats_of(input int code);
      case (code)
         1: return 2;
         2: return 4;
         3: return 8;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_col();
      if (e_row != 0) return (e_start + e_cnt) & CMASK;
      if (e_il != 0)  return e_start ^ e_cnt;
      return (e_start & ~(e_len - 1)) | ((e_start + e_cnt) & (e_len - 1));
   endfunction

   function automatic int exp_last();
      return (e_valid != 0 && e_row == 0 && e_cnt == e_len - 1) ? 1 : 0;
   endfunction

   task automatic model_step();
      int cur_last;
      cur_last = exp_last();
      if (col_cmd) begin
         e_valid = 1; e_cnt = 0; e_start = int'(col_start);
         e_row = (m_len == 7) ? 1 : 0;
         e_len = beats_of(m_len);
         e_il  = m_il;
      end else if (burst_stop) begin
         e_valid = 0;
      end else if (e_valid != 0) begin
         if (cur_last != 0) e_valid = 0;
         else e_cnt = (e_cnt + 1) & CMASK;
      end
      if (mode_wr) begin
         m_len = int'(mode_word[2:0]);
         m_il  = int'(mode_word[3]);
         m_lat = int'(mode_word[6:4]);
      end
   endtask

   task automatic check(input string tag);
      int ev, el, ec;
      ev = e_valid; el = exp_last(); ec = exp_col();
      checks++;
      if (int'(beat_valid) != ev || int'(beat_last) != el ||
          int'(rd_lat) != m_lat || (ev != 0 && int'(beat_col) != ec)) begin
         errors++;
         $display("FAIL %s: valid=%0d last=%0d col=%0h lat=%0d expected valid=%0d last=%0d col=%0h lat=%0d",
                  tag, beat_valid, beat_last, beat_col, rd_lat, ev, el, ec, m_lat);
      end
   endtask

   task automatic cyc(input bit mw, input int mword, input bit cc, input int cs,
                      input bit bs, input string tag);
      mode_wr = mw; mode_word = 7'(mword); col_cmd = cc;
      col_start = COL_W'(cs); burst_stop = bs;
      @(posedge clk);
      model_step();
      @(negedge clk);
      mode_wr = 1'b0; col_cmd = 1'b0; burst_stop = 1'b0;
      check(tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, tag);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1");
      rst_n = 1'b1;
      idle(2, "R11");
      // R2: latency 3, sequential, length 4
      cyc(1, 7'h32, 0, 0, 0, "R2");
      // R5: wrap inside a 4-beat block at the top of the row
      cyc(0, 0, 1, 10'h3FE, 0, "R3");
      idle(4, "R5");
      // R6: interleaved, length 8
      cyc(1, 7'h2B, 0, 0, 0, "R2");
      cyc(0, 0, 1, 10'h005, 0, "R6");
      idle(8, "R6");
      // R4: reserved code gives one beat; lengths 1 and 2
      cyc(1, 7'h25, 0, 0, 0, "R2");
      cyc(0, 0, 1, 10'h123, 0, "R4");
      idle(2, "R4");
      cyc(1, 7'h21, 0, 0, 0, "R2");
      cyc(0, 0, 1, 10'h0FF, 0, "R4");
      idle(3, "R4");
      // R7: whole row, interleave bit ignored, wraps past top
      cyc(1, 7'h3F, 0, 0, 0, "R2");
      cyc(0, 0, 1, 10'h3FD, 0, "R7");
      idle(6, "R7");
      // R8: stop a whole-row burst
      cyc(0, 0, 0, 0, 1, "R8");
      idle(2, "R8");
      // R9: restart mid-burst; R8 stop and command together
      cyc(1, 7'h23, 0, 0, 0, "R2");
      cyc(0, 0, 1, 10'h010, 0, "R3");
      idle(2, "R9");
      cyc(0, 0, 1, 10'h2A6, 0, "R9");
      idle(2, "R9");
      cyc(0, 0, 1, 10'h100, 1, "R8");
      // R10: mode write during burst does not change it
      cyc(1, 7'h28, 0, 0, 0, "R10");
      idle(8, "R10");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         bit mw, cc, bs;
         string tag;
         mw = ($urandom % 16) == 0;
         cc = ($urandom % 8) == 0;
         bs = ($urandom % 20) == 0;
         tag = (e_row != 0) ? "R7" : (e_il != 0) ? "R6" : "R5";
         if (e_valid == 0 && !cc) tag = "R11";
         cyc(mw, int'($urandom % 128), cc, int'($urandom % 1024), bs, tag);
      end
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule